// File: doc/BRIEF.md
# Twisted-Ring Decade Divider with One-Hot Decode

This block divides a count event stream by ten. Its state is a five-bit twisted-ring (Johnson) register, which steps through ten codes by shifting the inverted top bit into the bottom. Each of the ten one-hot outputs is decoded from two neighbouring register bits, so no output depends on more than a two-input gate. A carry output is high for the first half of the cycle and low for the second half. A second divider can take this carry as its count input, which gives a divide-by-hundred chain.

There are two control inputs. `count_in` is the event input. `hold_in` is active high and blocks counting. Both inputs are resynchronised to the system clock and then edge-detected. The count advances by one on either of two events. The first is a rising `count_in` edge while `hold_in` is low. The second is a falling `hold_in` edge while `count_in` is high. A synchronous `rst` returns the counter to state 0 and takes priority over any count event. The data here is a bare level stream with no transfer semantics, so no pin uses a valid/ready handshake and no back-pressure applies.

Top module: `decade_ring_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the state is forced to 0 whatever the other inputs do. After that edge, `dec_out` equals 10'b0000000001 and `carry_out` is 1. Releasing `rst` while `count_in` is held steady at 1 causes no advance.
- R2: After reset, `dec_out` always has exactly one bit high. Bit k high means state k. The internal register only ever holds one of the ten legal twisted-ring codes.
- R3: A 0→1 change of `count_in` while `hold_in` is 0 advances the state by one. The new `dec_out` is visible after the third rising clock edge that follows the input change: two edges for synchronisation and one for the state register.
- R4: A 1→0 change of `hold_in` while `count_in` is 1 advances the state by one, with the same three-edge latency.
- R5: While `hold_in` is 1, changes of `count_in` in either direction leave the state unchanged.
- R6: A 1→0 change of `count_in`, a 0→1 change of `hold_in`, and a 1→0 change of `hold_in` while `count_in` is 0 all leave the state unchanged.
- R7: `carry_out` is 1 in states 0 through 4 and 0 in states 5 through 9.
- R8: Advancing from state 9 gives state 0. Advancing from any other state k gives state k+1, so `dec_out` rotates left by one bit.
- R9: A rising `count_in` and a falling `hold_in` in the same synchronised cycle advance the state exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous master reset, active high |
| count_in | input | 1 | Count event input, asynchronous to clk |
| hold_in | input | 1 | Count inhibit, active high, asynchronous to clk |
| dec_out | output | 10 | One-hot decoded state, bit k for state k |
| carry_out | output | 1 | High in states 0–4, low in states 5–9 |

## Verification
The hardest case to reach from the ports is two qualifying events that land in the same synchronised cycle. This case must still give only one step. The bench reaches it by first parking `count_in` low with `hold_in` high. It then flips both inputs on the same falling clock edge, so both pass through identical synchroniser depths and arrive together. A reset asserted at the same edge as a count edge, followed by a release with `count_in` still high, covers the second awkward window.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DCR_STAGES     = 5;
  localparam int DCR_SYNC_DEPTH = 2;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } dcr_edge_t;
endpackage

// File: rtl/dcr_edge.sv
module dcr_edge #(
  parameter int DEPTH = dcr_pkg::DCR_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              din,
  output dcr_pkg::dcr_edge_t ev
);
  logic [DEPTH-1:0] sync_q;
  logic             prev_q;

  // Free-running chain: edges are judged against the last sampled level,
  // so a level held across reset release is not mistaken for an edge.
  always_ff @(posedge clk) begin
    sync_q <= {sync_q[DEPTH-2:0], din};
    prev_q <= sync_q[DEPTH-1];
  end

  always_comb begin
    ev.lvl  = sync_q[DEPTH-1];
    ev.rise = sync_q[DEPTH-1] & ~prev_q;
    ev.fall = ~sync_q[DEPTH-1] & prev_q;
  end
endmodule

// File: rtl/dcr_johnson.sv
module dcr_johnson #(
  parameter int STAGES = dcr_pkg::DCR_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [STAGES-1:0] q
);
  logic [STAGES-2:0] bounds;
  logic              legal;
  logic [STAGES-1:0] next_q;

  // A legal code has at most one boundary between neighbouring bits.
  always_comb begin
    bounds = q[STAGES-2:0] ^ q[STAGES-1:1];
    legal  = ($countones(bounds) <= 1);
    next_q = legal ? {q[STAGES-2:0], ~q[STAGES-1]} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (adv) q <= next_q;
  end
endmodule

// File: rtl/dcr_decode.sv
module dcr_decode #(
  parameter int STAGES = dcr_pkg::DCR_STAGES,
  localparam int NOUT  = 2 * STAGES
) (
  input  logic [STAGES-1:0] q,
  output logic [NOUT-1:0]   dec,
  output logic              carry
);
  assign dec[0]      = ~q[STAGES-1] & ~q[0];
  assign dec[STAGES] =  q[STAGES-1] &  q[0];

  for (genvar k = 1; k < STAGES; k++) begin : g_fill
    assign dec[k]          =  q[k-1] & ~q[k];
    assign dec[STAGES + k] = ~q[k-1] &  q[k];
  end

  assign carry = ~q[STAGES-1];
endmodule

// File: rtl/decade_ring_counter.sv
module decade_ring_counter #(
  parameter int STAGES     = dcr_pkg::DCR_STAGES,
  parameter int SYNC_DEPTH = dcr_pkg::DCR_SYNC_DEPTH,
  localparam int NOUT      = 2 * STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            count_in,
  input  logic            hold_in,
  output logic [NOUT-1:0] dec_out,
  output logic            carry_out
);
  dcr_pkg::dcr_edge_t cnt_ev, hld_ev;
  logic               advance;
  logic [STAGES-1:0]  state_q;

  dcr_edge #(.DEPTH(SYNC_DEPTH)) u_cnt_edge (.clk(clk), .din(count_in), .ev(cnt_ev));
  dcr_edge #(.DEPTH(SYNC_DEPTH)) u_hld_edge (.clk(clk), .din(hold_in),  .ev(hld_ev));

  // Both qualifying events are OR-ed into a single step.
  assign advance = (cnt_ev.rise & ~hld_ev.lvl) | (hld_ev.fall & cnt_ev.lvl);

  dcr_johnson #(.STAGES(STAGES)) u_ring (
    .clk(clk), .rst(rst), .adv(advance), .q(state_q)
  );

  dcr_decode #(.STAGES(STAGES)) u_dec (
    .q(state_q), .dec(dec_out), .carry(carry_out)
  );
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int STAGES = dcr_pkg::DCR_STAGES,
  localparam int NOUT  = 2 * STAGES
) (
  input logic              clk,
  input logic              rst,
  input logic [NOUT-1:0]   dec_out,
  input logic              carry_out,
  input logic [STAGES-1:0] state
);
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dec_out == NOUT'(1) && carry_out));

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(dec_out));

  a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
    $countones(state[STAGES-2:0] ^ state[STAGES-1:1]) <= 1);

  a_r7_carry_half: assert property (@(posedge clk) disable iff (rst)
    carry_out == (|dec_out[STAGES-1:0]));

  a_r8_rotate_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(dec_out)) |->
      dec_out == {$past(dec_out[NOUT-2:0]), $past(dec_out[NOUT-1])});
endmodule

bind decade_ring_counter dcr_checker #(.STAGES(STAGES)) u_dcr_chk (
  .clk(clk), .rst(rst), .dec_out(dec_out), .carry_out(carry_out), .state(state_q)
);

// File: tb/decade_ring_counter_test.sv
module decade_ring_counter_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NOUT = 10;

  logic clk = 1'b0, rst = 1'b1, count_in = 1'b0, hold_in = 1'b0;
  logic [NOUT-1:0] dec_out;
  logic carry_out;
  int n_cmp = 0, n_bad = 0, exp_st = 0;

  decade_ring_counter uut (
    .clk(clk), .rst(rst), .count_in(count_in), .hold_in(hold_in),
    .dec_out(dec_out), .carry_out(carry_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag);
    logic [NOUT-1:0] e_dec = NOUT'(1) << exp_st;
    logic e_c = (exp_st < 5);
    n_cmp++;
    if (dec_out !== e_dec || carry_out !== e_c) begin
      n_bad++;
      $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b",
               tag, dec_out, carry_out, e_dec, e_c);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    step(6);
    rst = 1'b0;
    exp_st = 0;
    check("R1 reset state");

    // R3 latency: unchanged after two edges, stepped after three.
    count_in = 1'b1; step(2);
    check("R3 latency two edges");
    step(1); exp_st = 1;
    check("R3 latency three edges");
    count_in = 1'b0; step(4);
    check("R6 count fall ignored");

    // R3/R7/R8: a full cycle of count edges, including the wrap.
    for (int i = 0; i < 10; i++) begin
      count_in = 1'b1; step(4);
      exp_st = (exp_st + 1) % 10;
      check("R3 R7 R8 count advance");
      count_in = 1'b0; step(4);
      check("R6 count fall");
    end

    // R5: blocked while hold is high.
    hold_in = 1'b1; step(4);
    check("R6 hold rise ignored");
    for (int i = 0; i < 3; i++) begin
      count_in = 1'b1; step(4); check("R5 blocked rise");
      count_in = 1'b0; step(4); check("R5 blocked fall");
    end
    hold_in = 1'b0; step(4);
    check("R6 hold fall with count low");

    // R4: ten advances by hold release with count high.
    hold_in = 1'b1; step(4);
    count_in = 1'b1; step(4);
    check("R5 rise under hold");
    for (int i = 0; i < 10; i++) begin
      hold_in = 1'b0; step(4);
      exp_st = (exp_st + 1) % 10;
      check("R4 R7 R8 hold release advance");
      hold_in = 1'b1; step(4);
      check("R6 hold rise");
    end

    // R9: both events land in the same cycle.
    count_in = 1'b0; step(4);
    check("R5 fall under hold");
    count_in = 1'b1; hold_in = 1'b0; step(4);
    exp_st = (exp_st + 1) % 10;
    check("R9 coincident events");
    step(6);
    check("R9 single step only");

    // R1: reset overrides a simultaneous count edge.
    count_in = 1'b0; step(4);
    count_in = 1'b1; step(4); exp_st = (exp_st + 1) % 10;
    count_in = 1'b0; step(4);
    check("R8 pre-reset state");
    rst = 1'b1; count_in = 1'b1; step(5);
    rst = 1'b0; exp_st = 0;
    check("R1 reset priority");
    step(6);
    check("R1 no advance on release");

    finish_run();
  end
endmodule